// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor. The processor shares one memory and one ALU across several clock cycles per instruction. The sequencer is a Moore-style state machine. It reads the 6-bit opcode held in the instruction register and the ALU zero flag. In every state it drives the full set of datapath control lines: the memory address source, memory read and write strobes, instruction register load, both ALU operand selects, the ALU operation class, the PC load and PC source, the register-file destination select, the register-file write enable and the write-back source.

Every instruction begins with two shared states, FETCH and DECODE. After DECODE the machine branches on the opcode class:
- Load: MEM_ADDR, MEM_READ, LOAD_WB.
- Store: MEM_ADDR, MEM_WRITE.
- R-type: EXECUTE, ALU_WB.
- Branch-on-equal: BRANCH.

Transitions are named as follows:
- T_FETCH_DECODE: FETCH to DECODE, always taken.
- T_DECODE_DISPATCH: DECODE to MEM_ADDR for load or store, to EXECUTE for R-type, to BRANCH for branch, and to FETCH for any other opcode.
- T_ADDR_SPLIT: MEM_ADDR to MEM_READ for load, otherwise to MEM_WRITE.
- T_READ_WB: MEM_READ to LOAD_WB.
- T_EXEC_WB: EXECUTE to ALU_WB.
- T_RETIRE: LOAD_WB, MEM_WRITE, ALU_WB and BRANCH to FETCH.

A synchronous reset forces FETCH.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is FETCH, whatever the current state.
- R2: In FETCH, `mem_rd`=1, `ir_load`=1 and `pc_wr`=1. Also `addr_from_alu`=0, `alu_a_sel`=0, `alu_b_sel`=2'b01 (constant 4), `alu_class`=2'b00 (add) and `pc_src`=2'b00 (ALU result). All other outputs are 0.
- R3: DECODE always follows FETCH. It drives `alu_b_sel`=2'b11 (shifted offset) and `alu_class`=2'b00, with all other outputs 0.
- R4: A load (opcode 6'h23) takes 5 cycles. MEM_ADDR drives `alu_a_sel`=1, `alu_b_sel`=2'b10 and `alu_class`=2'b00. MEM_READ drives `addr_from_alu`=1 and `mem_rd`=1. LOAD_WB drives `rf_wr`=1, `wb_from_mem`=1 and `dst_is_rd`=0. The next state is FETCH.
- R5: A store (opcode 6'h2B) takes 4 cycles. After MEM_ADDR comes MEM_WRITE, which drives `addr_from_alu`=1 and `mem_wr`=1. The next state is FETCH.
- R6: An R-type (opcode 6'h00) takes 4 cycles. EXECUTE drives `alu_a_sel`=1, `alu_b_sel`=2'b00 and `alu_class`=2'b10. ALU_WB drives `dst_is_rd`=1, `rf_wr`=1 and `wb_from_mem`=0. The next state is FETCH.
- R7: A branch-on-equal (opcode 6'h04) takes 3 cycles. BRANCH drives `alu_a_sel`=1, `alu_b_sel`=2'b00, `alu_class`=2'b01 and `pc_src`=2'b01. In that state `pc_wr` equals `alu_zero`.
- R8: Any other opcode returns from DECODE straight to FETCH.
- R9: `alu_zero` has no effect outside BRANCH. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| addr_from_alu | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| alu_a_sel | output | 1 | ALU operand A: PC (0) or register A (1) |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 constant 4, 10 immediate, 11 shifted offset |
| alu_class | output | 2 | 00 add, 01 subtract, 10 from function field |
| pc_wr | output | 1 | PC load enable |
| pc_src | output | 2 | PC source: 00 ALU result, 01 stored target |
| dst_is_rd | output | 1 | Register destination: rd (1) or rt (0) |
| rf_wr | output | 1 | Register file write enable |
| wb_from_mem | output | 1 | Write-back data from memory (1) or ALU output (0) |

## Verification
The bench runs every instruction class and compares the full control vector in every state. This catches a sequencer that skips or repeats a state, or that leaves a strobe high in a state that should clear it.

Branch is run with the zero flag both high and low. A design that writes the PC unconditionally would send a not-taken branch to the wrong place.

Load is also run with the zero flag held high throughout. Any leak of the flag into non-branch states would show up as a spurious PC write.

An unknown opcode must bounce back to FETCH after DECODE. A reset asserted in the middle of a store must land in FETCH, not in MEM_WRITE.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_MEM_ADDR  = 4'd2,
        ST_MEM_READ  = 4'd3,
        ST_LOAD_WB   = 4'd4,
        ST_MEM_WRITE = 4'd5,
        ST_EXECUTE   = 4'd6,
        ST_ALU_WB    = 4'd7,
        ST_BRANCH    = 4'd8
    } state_t;

    typedef enum logic [2:0] {
        CLS_RTYPE  = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_OTHER  = 3'd4
    } instr_cls_t;

    localparam logic [1:0] BSEL_REG   = 2'b00;
    localparam logic [1:0] BSEL_FOUR  = 2'b01;
    localparam logic [1:0] BSEL_IMM   = 2'b10;
    localparam logic [1:0] BSEL_SHIFT = 2'b11;

    localparam logic [1:0] ACLS_ADD   = 2'b00;
    localparam logic [1:0] ACLS_SUB   = 2'b01;
    localparam logic [1:0] ACLS_FUNCT = 2'b10;

    localparam logic [1:0] PCSRC_ALU    = 2'b00;
    localparam logic [1:0] PCSRC_TARGET = 2'b01;

    typedef struct packed {
        logic       addr_from_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_load;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_class;
        logic       pc_wr;
        logic [1:0] pc_src;
        logic       dst_is_rd;
        logic       rf_wr;
        logic       wb_from_mem;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcc_op_decode.sv
module mcc_op_decode
    import mcc_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'h00,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'h04
) (
    input  logic [OP_W-1:0] opcode,
    output instr_cls_t      cls
);

    always_comb begin
        if (opcode == OP_RTYPE)       cls = CLS_RTYPE;
        else if (opcode == OP_LOAD)   cls = CLS_LOAD;
        else if (opcode == OP_STORE)  cls = CLS_STORE;
        else if (opcode == OP_BRANCH) cls = CLS_BRANCH;
        else                          cls = CLS_OTHER;
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_t     cur,
    input  instr_cls_t cls,
    output state_t     nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:     nxt = ST_DECODE;                      // T_FETCH_DECODE
            ST_DECODE: begin                                    // T_DECODE_DISPATCH
                unique case (cls)
                    CLS_LOAD, CLS_STORE: nxt = ST_MEM_ADDR;
                    CLS_RTYPE:           nxt = ST_EXECUTE;
                    CLS_BRANCH:          nxt = ST_BRANCH;
                    default:             nxt = ST_FETCH;
                endcase
            end
            ST_MEM_ADDR:  nxt = (cls == CLS_LOAD) ? ST_MEM_READ  // T_ADDR_SPLIT
                                                  : ST_MEM_WRITE;
            ST_MEM_READ:  nxt = ST_LOAD_WB;                     // T_READ_WB
            ST_EXECUTE:   nxt = ST_ALU_WB;                      // T_EXEC_WB
            ST_LOAD_WB,
            ST_MEM_WRITE,
            ST_ALU_WB,
            ST_BRANCH:    nxt = ST_FETCH;                       // T_RETIRE
            default:      nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  state_t cur,
    input  logic   alu_zero,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = CTRL_IDLE;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_load   = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_class = ACLS_ADD;
                ctl.pc_wr     = 1'b1;
                ctl.pc_src    = PCSRC_ALU;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSEL_SHIFT;
                ctl.alu_class = ACLS_ADD;
            end
            ST_MEM_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_class = ACLS_ADD;
            end
            ST_MEM_READ: begin
                ctl.addr_from_alu = 1'b1;
                ctl.mem_rd        = 1'b1;
            end
            ST_MEM_WRITE: begin
                ctl.addr_from_alu = 1'b1;
                ctl.mem_wr        = 1'b1;
            end
            ST_LOAD_WB: begin
                ctl.rf_wr       = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_EXECUTE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_class = ACLS_FUNCT;
            end
            ST_ALU_WB: begin
                ctl.dst_is_rd = 1'b1;
                ctl.rf_wr     = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_class = ACLS_SUB;
                ctl.pc_src    = PCSRC_TARGET;
                ctl.pc_wr     = alu_zero;
            end
            default: ctl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'h00,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'h04
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    output logic            addr_from_alu,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_load,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_class,
    output logic            pc_wr,
    output logic [1:0]      pc_src,
    output logic            dst_is_rd,
    output logic            rf_wr,
    output logic            wb_from_mem
);

    state_t     state_q;
    state_t     state_d;
    instr_cls_t cls;
    ctrl_t      ctl;

    mcc_op_decode #(
        .OP_W     (OP_W),
        .OP_RTYPE (OP_RTYPE),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BRANCH(OP_BRANCH)
    ) op_dec_i (
        .opcode(opcode),
        .cls   (cls)
    );

    mcc_next_state nxt_i (
        .cur(state_q),
        .cls(cls),
        .nxt(state_d)
    );

    mcc_out_decode out_i (
        .cur     (state_q),
        .alu_zero(alu_zero),
        .ctl     (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        addr_from_alu = ctl.addr_from_alu;
        mem_rd        = ctl.mem_rd;
        mem_wr        = ctl.mem_wr;
        ir_load       = ctl.ir_load;
        alu_a_sel     = ctl.alu_a_sel;
        alu_b_sel     = ctl.alu_b_sel;
        alu_class     = ctl.alu_class;
        pc_wr         = ctl.pc_wr;
        pc_src        = ctl.pc_src;
        dst_is_rd     = ctl.dst_is_rd;
        rf_wr         = ctl.rf_wr;
        wb_from_mem   = ctl.wb_from_mem;
    end

endmodule

// File: rtl/mcc_ctrl_fsm_chk.sv
module mcc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_zero,
    input logic       addr_from_alu,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_load,
    input logic [1:0] alu_b_sel,
    input logic [1:0] alu_class,
    input logic       pc_wr,
    input logic [1:0] pc_src,
    input logic       dst_is_rd,
    input logic       rf_wr,
    input logic       wb_from_mem
);

    AST_RESET_TO_FETCH: assert property (@(posedge clk) rst |=> (ir_load && mem_rd && !addr_from_alu)); // R1
    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst) ir_load |=> (alu_b_sel == 2'b11 && !ir_load)); // R3
    AST_LOAD_WB_AFTER_READ: assert property (@(posedge clk) disable iff (rst) (rf_wr && wb_from_mem) |-> $past(mem_rd && addr_from_alu)); // R4
    AST_STORE_RETIRES: assert property (@(posedge clk) disable iff (rst) mem_wr |=> ir_load); // R5
    AST_RTYPE_WB_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst) (rf_wr && dst_is_rd) |-> $past(alu_class == 2'b10)); // R6
    AST_BRANCH_COND_PC: assert property (@(posedge clk) disable iff (rst) (pc_src == 2'b01) |-> (pc_wr == alu_zero)); // R7
    AST_NO_RD_WR_CLASH: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R9

endmodule

bind mcc_ctrl_fsm mcc_ctrl_fsm_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .alu_zero     (alu_zero),
    .addr_from_alu(addr_from_alu),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .ir_load      (ir_load),
    .alu_b_sel    (alu_b_sel),
    .alu_class    (alu_class),
    .pc_wr        (pc_wr),
    .pc_src       (pc_src),
    .dst_is_rd    (dst_is_rd),
    .rf_wr        (rf_wr),
    .wb_from_mem  (wb_from_mem)
);

// File: tb/mcc_ctrl_fsm_tb_top.sv
module mcc_ctrl_fsm_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic       addr_from_alu, mem_rd, mem_wr, ir_load, alu_a_sel;
    logic [1:0] alu_b_sel, alu_class, pc_src;
    logic       pc_wr, dst_is_rd, rf_wr, wb_from_mem;

    typedef struct {
        logic [14:0] vec;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcc_ctrl_fsm dut_i (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_load(ir_load), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_class(alu_class), .pc_wr(pc_wr), .pc_src(pc_src),
        .dst_is_rd(dst_is_rd), .rf_wr(rf_wr), .wb_from_mem(wb_from_mem)
    );

    function automatic logic [14:0] mk(
        input logic iord, input logic mrd, input logic mwr, input logic irw,
        input logic asel, input logic [1:0] bsel, input logic [1:0] acls,
        input logic pcw, input logic [1:0] psrc, input logic rdst,
        input logic rfw, input logic m2r);
        return {iord, mrd, mwr, irw, asel, bsel, acls, pcw, psrc, rdst, rfw, m2r};
    endfunction

    function automatic logic [14:0] e_fetch();    return mk(0,1,0,1,0,2'b01,2'b00,1,2'b00,0,0,0); endfunction
    function automatic logic [14:0] e_decode();   return mk(0,0,0,0,0,2'b11,2'b00,0,2'b00,0,0,0); endfunction
    function automatic logic [14:0] e_addr();     return mk(0,0,0,0,1,2'b10,2'b00,0,2'b00,0,0,0); endfunction
    function automatic logic [14:0] e_mread();    return mk(1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0,0); endfunction
    function automatic logic [14:0] e_mwrite();   return mk(1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0,0); endfunction
    function automatic logic [14:0] e_ldwb();     return mk(0,0,0,0,0,2'b00,2'b00,0,2'b00,0,1,1); endfunction
    function automatic logic [14:0] e_exec();     return mk(0,0,0,0,1,2'b00,2'b10,0,2'b00,0,0,0); endfunction
    function automatic logic [14:0] e_rwb();      return mk(0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1,0); endfunction
    function automatic logic [14:0] e_branch(input logic z);
        return mk(0,0,0,0,1,2'b00,2'b01,z,2'b01,0,0,0);
    endfunction

    // Driver: one call per cycle, at the falling edge.
    task automatic step(input logic [5:0] op, input logic z, input logic [14:0] v, input string tag);
        @(negedge clk);
        rst      = 1'b0;
        opcode   = op;
        alu_zero = z;
        exp_q.push_back('{vec: v, tag: tag});
    endtask

    task automatic run_load(input logic z, input string first_tag);
        step(6'h23, z, e_fetch(),  first_tag);
        step(6'h23, z, e_decode(), "R3");
        step(6'h23, z, e_addr(),   "R4");
        step(6'h23, z, e_mread(),  "R4");
        step(6'h23, z, e_ldwb(),   "R4");
    endtask

    task automatic run_store();
        step(6'h2B, 1'b0, e_fetch(),  "R2");
        step(6'h2B, 1'b1, e_decode(), "R3");
        step(6'h2B, 1'b0, e_addr(),   "R5");
        step(6'h2B, 1'b1, e_mwrite(), "R5");
    endtask

    task automatic run_rtype(input string first_tag);
        step(6'h00, 1'b0, e_fetch(),  first_tag);
        step(6'h00, 1'b0, e_decode(), "R3");
        step(6'h00, 1'b1, e_exec(),   "R6");
        step(6'h00, 1'b0, e_rwb(),    "R6");
    endtask

    task automatic run_branch(input logic z);
        step(6'h04, 1'b0, e_fetch(),    "R2");
        step(6'h04, 1'b0, e_decode(),   "R3");
        step(6'h04, z,    e_branch(z),  "R7");
    endtask

    // Monitor: compares after outputs settle past the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [14:0] act;
                e   = exp_q.pop_front();
                act = {addr_from_alu, mem_rd, mem_wr, ir_load, alu_a_sel, alu_b_sel,
                       alu_class, pc_wr, pc_src, dst_is_rd, rf_wr, wb_from_mem};
                n_checks++;
                if (act !== e.vec) begin
                    n_fails++;
                    $display("FAIL %s: control vector actual %b expected %b", e.tag, act, e.vec);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        run_load(1'b0, "R1");          // reset state is FETCH, then full load
        run_store();
        run_rtype("R2");
        run_branch(1'b1);              // taken
        run_branch(1'b0);              // not taken
        step(6'h3F, 1'b0, e_fetch(),  "R2");
        step(6'h3F, 1'b0, e_decode(), "R3");
        step(6'h00, 1'b0, e_fetch(),  "R8");   // unknown opcode bounced to FETCH
        step(6'h00, 1'b0, e_decode(), "R3");
        step(6'h00, 1'b0, e_exec(),   "R6");
        step(6'h00, 1'b0, e_rwb(),    "R6");
        run_load(1'b1, "R9");          // zero flag high through a load
        // reset mid-store
        step(6'h2B, 1'b0, e_fetch(),  "R2");
        step(6'h2B, 1'b0, e_decode(), "R3");
        step(6'h2B, 1'b0, e_addr(),   "R5");
        @(negedge clk);
        rst = 1'b1;
        run_rtype("R1");
        run_load(1'b1, "R2");
        @(negedge clk);
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule